// File: doc/BRIEF.md
# Lockable Fully Associative Translation Buffer

This block stores a small set of address translations, each as a pair of 64-bit words: a tag and a translation entry. Bit 63 of the translation entry marks it valid and bit 6 locks it against automatic replacement. Software loads a tag-access register with the tag it wants to install. It then writes the translation entry in one of two ways. An automatic write picks a victim slot itself. A direct write names the slot. Both take the tag from the tag-access register.

A search operation returns the supplied tag when a valid entry holds it. A small register file holds the tag-access register, a fault-status register and a fault-address register. A fault-capture input loads the two fault registers from the surrounding pipeline. Every request is accepted in one cycle and answered by a one-cycle done pulse on the following cycle.

Top module: `xlat_buffer`

## Requirements
- R1: After reset every entry is invalid (entry reads return 0), every register reads 0, and respDone, respData and fullDrop are 0.
- R2: Every accepted request (reqValid high for one cycle) produces exactly one respDone pulse, in the cycle after the request.
- R3: An automatic write (reqOp 2) installs reqData as the entry, and the tag-access register (register 6) as the tag, in the lowest-numbered slot whose bit 63 is clear. An unlocked valid slot elsewhere does not take priority over an invalid slot.
- R4: When every slot is valid, an automatic write uses the lowest-numbered slot whose lock bit (bit 6) is clear.
- R5: When every slot is valid and locked, an automatic write changes no slot and fullDrop pulses high together with respDone.
- R6: A direct write (reqOp 3) stores reqData, with register 6 as its tag, in the slot given by reqAddr[8:3].
- R7: A search (reqOp 4) returns reqData when a slot with bit 63 set holds a tag equal to reqData. Otherwise it returns 0, and slots with bit 63 clear never match.
- R8: Register reads (reqOp 0) and writes (reqOp 1) select the register with reqAddr[6:3]. Writes to register 0 and register 4 have no effect.
- R9: Writing register 3 with data bit 0 clear sets both register 3 and register 4 to 0. Writing it with bit 0 set stores the data and leaves register 4 unchanged.
- R10: A cycle with faultLog high loads faultStatusIn into register 3 and faultAddrIn into register 4. It wins over a register write in the same cycle.
- R11: An entry read (reqOp 5) returns the translation entry held in slot reqAddr[8:3].
- R12: Codes 6 and 7 on reqOp change no state, still pulse respDone, and return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, one cycle per request |
| reqOp | input | 3 | Operation code (0 reg read, 1 reg write, 2 automatic write, 3 direct write, 4 search, 5 entry read) |
| reqAddr | input | 16 | Slot index in bits [8:3], register index in bits [6:3] |
| reqData | input | 64 | Write data or search tag |
| faultLog | input | 1 | Capture the fault inputs into registers 3 and 4 |
| faultStatusIn | input | 64 | Fault status value to capture |
| faultAddrIn | input | 64 | Fault address value to capture |
| respDone | output | 1 | One-cycle completion pulse |
| respData | output | 64 | Read or search result, valid while respDone is high |
| fullDrop | output | 1 | Pulses with respDone when an automatic write was discarded |

## Verification
Every result, including respData, fullDrop and respDone, passes through exactly one register. It therefore appears one clock edge after the edge that accepts the request. State changes made by a write become visible to a request issued on the next cycle. The bench drives each request on a falling edge and samples the outputs on the next falling edge, which lies half a period after the edge that produced them. A capture on faultLog is likewise checked by a register read issued only after that capture edge. Effects of automatic writes are confirmed by reading back the chosen slot and its neighbours, and by searching for the installed and the displaced tags.

// File: rtl/xbuf_pkg.sv
package xbuf_pkg;
  typedef enum logic [2:0] {
    OP_REG_RD   = 3'd0,
    OP_REG_WR   = 3'd1,
    OP_AUTO_WR  = 3'd2,
    OP_DIRECT_WR = 3'd3,
    OP_SEARCH   = 3'd4,
    OP_ENTRY_RD = 3'd5
  } op_e;

  typedef struct packed {
    logic regRd;
    logic regWr;
    logic autoWr;
    logic directWr;
    logic search;
    logic entryRd;
  } strobe_t;

  localparam int VALID_BIT = 63;
  localparam int LOCK_BIT  = 6;
  localparam int TAG_REG   = 6;
  localparam int FSR_REG   = 3;
  localparam int FAR_REG   = 4;
  localparam int RO_REG    = 0;
  localparam int ADDR_LSB  = 3;
endpackage

// File: rtl/xbuf_first.sv
module xbuf_first #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/xbuf_ctrl.sv
module xbuf_ctrl
  import xbuf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  output strobe_t    strb,
  output logic       respDone
);
  always_comb begin
    strb          = '0;
    strb.regRd    = reqValid && (reqOp == OP_REG_RD);
    strb.regWr    = reqValid && (reqOp == OP_REG_WR);
    strb.autoWr   = reqValid && (reqOp == OP_AUTO_WR);
    strb.directWr = reqValid && (reqOp == OP_DIRECT_WR);
    strb.search   = reqValid && (reqOp == OP_SEARCH);
    strb.entryRd  = reqValid && (reqOp == OP_ENTRY_RD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) respDone <= 1'b0;
    else       respDone <= reqValid;
  end

  // R2: a done pulse only ever follows an accepted request
  p_done_after_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    respDone |-> $past(reqValid));

  // R12: at most one operation is decoded per cycle
  p_single_op_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb));
endmodule

// File: rtl/xbuf_store.sv
module xbuf_store
  import xbuf_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int DW      = 64,
  parameter int NREGS   = 16,
  localparam int IW     = $clog2(ENTRIES),
  localparam int RW     = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic [IW-1:0] entIdx,
  input  logic [RW-1:0] regIdx,
  input  logic [DW-1:0] reqData,
  input  logic          faultLog,
  input  logic [DW-1:0] faultStatusIn,
  input  logic [DW-1:0] faultAddrIn,
  output logic [DW-1:0] respData,
  output logic          fullDrop
);
  logic [DW-1:0] tagMem  [ENTRIES];
  logic [DW-1:0] tteMem  [ENTRIES];
  logic [DW-1:0] regFile [NREGS];

  logic [ENTRIES-1:0] validVec, unlockVec, hitVec, freeVec;
  logic               invFound, unlFound, hitFound, haveVictim;
  logic [IW-1:0]      invIdx, unlIdx, hitIdx, victimIdx;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    assign validVec[e]  = tteMem[e][VALID_BIT];
    assign unlockVec[e] = !tteMem[e][LOCK_BIT];
    assign freeVec[e]   = !tteMem[e][VALID_BIT];
    assign hitVec[e]    = tteMem[e][VALID_BIT] && (tagMem[e] == reqData);
  end

  xbuf_first #(.N(ENTRIES), .IW(IW)) u_pickInvalid (
    .req(freeVec), .found(invFound), .idx(invIdx));
  xbuf_first #(.N(ENTRIES), .IW(IW)) u_pickUnlocked (
    .req(unlockVec), .found(unlFound), .idx(unlIdx));
  xbuf_first #(.N(ENTRIES), .IW(IW)) u_pickHit (
    .req(hitVec), .found(hitFound), .idx(hitIdx));

  assign haveVictim = invFound || unlFound;
  assign victimIdx  = invFound ? invIdx : unlIdx;

  // Slot storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        tagMem[e] <= '0;
        tteMem[e] <= '0;
      end
    end else if (strb.directWr) begin
      tagMem[entIdx] <= regFile[TAG_REG];
      tteMem[entIdx] <= reqData;
    end else if (strb.autoWr && haveVictim) begin
      tagMem[victimIdx] <= regFile[TAG_REG];
      tteMem[victimIdx] <= reqData;
    end
  end

  // Register file
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NREGS; r++) regFile[r] <= '0;
    end else begin
      if (strb.regWr) begin
        if (regIdx == RW'(FSR_REG)) begin
          if (!reqData[0]) begin
            regFile[FSR_REG] <= '0;
            regFile[FAR_REG] <= '0;
          end else begin
            regFile[FSR_REG] <= reqData;
          end
        end else if (regIdx != RW'(RO_REG) && regIdx != RW'(FAR_REG)) begin
          regFile[regIdx] <= reqData;
        end
      end
      if (faultLog) begin
        regFile[FSR_REG] <= faultStatusIn;
        regFile[FAR_REG] <= faultAddrIn;
      end
    end
  end

  // Response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respData <= '0;
      fullDrop <= 1'b0;
    end else begin
      respData <= '0;
      if (strb.regRd)        respData <= regFile[regIdx];
      else if (strb.search)  respData <= hitFound ? tagMem[hitIdx] : '0;
      else if (strb.entryRd) respData <= tteMem[entIdx];
      fullDrop <= strb.autoWr && !haveVictim;
    end
  end

  // R5: a drop is only reported when every slot was valid and locked
  p_drop_all_locked_r5: assert property (@(posedge clk) disable iff (!rstN)
    fullDrop |-> (($past(validVec) & $past(unlockVec)) == '0) && ($past(validVec) == '1));

  // R3: an accepted automatic write leaves the victim holding the new valid bit
  p_victim_written_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.autoWr && haveVictim && !strb.directWr) |=>
      (validVec[$past(victimIdx)] == $past(reqData[VALID_BIT])));

  // R7: a search that finds nothing answers zero
  p_search_miss_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.search && !hitFound) |=> (respData == '0));

  // R8: the fault-address register moves only on a capture or a status write
  p_far_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!faultLog && !(strb.regWr && regIdx == RW'(FSR_REG))) |=> $stable(regFile[FAR_REG]));
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
  import xbuf_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int DW      = 64,
  parameter int NREGS   = 16,
  parameter int AW      = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [2:0]    reqOp,
  input  logic [AW-1:0] reqAddr,
  input  logic [DW-1:0] reqData,
  input  logic          faultLog,
  input  logic [DW-1:0] faultStatusIn,
  input  logic [DW-1:0] faultAddrIn,
  output logic          respDone,
  output logic [DW-1:0] respData,
  output logic          fullDrop
);
  localparam int IW = $clog2(ENTRIES);
  localparam int RW = $clog2(NREGS);

  strobe_t       strb;
  logic [IW-1:0] entIdx;
  logic [RW-1:0] regIdx;
  logic          unusedAddr;

  assign entIdx     = reqAddr[ADDR_LSB +: IW];
  assign regIdx     = reqAddr[ADDR_LSB +: RW];
  assign unusedAddr = ^{reqAddr[ADDR_LSB-1:0], reqAddr[AW-1:ADDR_LSB+IW]};

  xbuf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .strb(strb), .respDone(respDone));

  xbuf_store #(.ENTRIES(ENTRIES), .DW(DW), .NREGS(NREGS)) u_store (
    .clk(clk), .rstN(rstN), .strb(strb), .entIdx(entIdx), .regIdx(regIdx),
    .reqData(reqData), .faultLog(faultLog), .faultStatusIn(faultStatusIn),
    .faultAddrIn(faultAddrIn), .respData(respData), .fullDrop(fullDrop));

  // R5: a drop report always coincides with its done pulse
  p_drop_with_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    fullDrop |-> respDone);
endmodule

// File: tb/xlat_buffer_test.sv
module xlat_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] OP_RR = 3'd0, OP_RW = 3'd1, OP_AUTO = 3'd2,
                         OP_DIR = 3'd3, OP_SRCH = 3'd4, OP_ERD = 3'd5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = '0;
  logic [15:0] reqAddr = '0;
  logic [63:0] reqData = '0;
  logic        faultLog = 1'b0;
  logic [63:0] faultStatusIn = '0;
  logic [63:0] faultAddrIn = '0;
  logic        respDone;
  logic [63:0] respData;
  logic        fullDrop;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [63:0] gotData;
  logic        gotDone, gotFull;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_buffer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .faultLog(faultLog),
    .faultStatusIn(faultStatusIn), .faultAddrIn(faultAddrIn),
    .respDone(respDone), .respData(respData), .fullDrop(fullDrop));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkTte(input bit v, input bit l, input logic [15:0] tagv);
    logic [63:0] t = '0;
    t[63] = v;
    t[6] = l;
    t[31:16] = tagv;
    return t;
  endfunction

  // one request: drive on falling edge, sample on the next falling edge
  task automatic issue(input logic [2:0] op, input int idx, input logic [63:0] d);
    @(negedge clk);
    reqValid = 1'b1;
    reqOp = op;
    reqAddr = 16'(idx << 3);
    reqData = d;
    @(negedge clk);
    gotData = respData;
    gotDone = respDone;
    gotFull = fullDrop;
    reqValid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 done low", {63'd0, respDone}, 64'd0);
    check("R1 data zero", respData, 64'd0);
    check("R1 full low", {63'd0, fullDrop}, 64'd0);
    issue(OP_ERD, 5, '0);
    check("R1 R11 entry empty", gotData, 64'd0);
    issue(OP_RR, 6, '0);
    check("R1 tag reg zero", gotData, 64'd0);
  endtask

  task automatic t_regs();
    issue(OP_RW, 6, 64'h0123_4567_89AB_CDEF);
    check("R2 done on write", {63'd0, gotDone}, 64'd1);
    @(negedge clk);
    check("R2 single pulse", {63'd0, respDone}, 64'd0);
    issue(OP_RR, 6, '0);
    check("R8 reg6 readback", gotData, 64'h0123_4567_89AB_CDEF);
    check("R2 done on read", {63'd0, gotDone}, 64'd1);
    issue(OP_RW, 0, 64'hFFFF);
    issue(OP_RR, 0, '0);
    check("R8 reg0 read-only", gotData, 64'd0);
    issue(OP_RW, 4, 64'hAAAA);
    issue(OP_RR, 4, '0);
    check("R8 reg4 read-only", gotData, 64'd0);
  endtask

  task automatic t_fault();
    @(negedge clk);
    faultLog = 1'b1;
    faultStatusIn = 64'hF5;
    faultAddrIn = 64'h1234;
    @(negedge clk);
    faultLog = 1'b0;
    issue(OP_RR, 3, '0);
    check("R10 status captured", gotData, 64'hF5);
    issue(OP_RR, 4, '0);
    check("R10 address captured", gotData, 64'h1234);
    issue(OP_RW, 3, 64'hA1);
    issue(OP_RR, 3, '0);
    check("R9 status set", gotData, 64'hA1);
    issue(OP_RR, 4, '0);
    check("R9 address kept", gotData, 64'h1234);
    issue(OP_RW, 3, 64'h40);
    issue(OP_RR, 3, '0);
    check("R9 status cleared", gotData, 64'd0);
    issue(OP_RR, 4, '0);
    check("R9 address cleared", gotData, 64'd0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 64; i++) begin
      issue(OP_RW, 6, 64'h1000 + 64'(i));
      issue(OP_AUTO, 0, mkTte(1, 1, 16'(i)));
      if (gotFull) check("R3 no drop while filling", 64'd1, 64'd0);
    end
    issue(OP_ERD, 0, '0);
    check("R3 R11 slot0", gotData, mkTte(1, 1, 16'd0));
    issue(OP_ERD, 31, '0);
    check("R3 slot31", gotData, mkTte(1, 1, 16'd31));
    issue(OP_ERD, 63, '0);
    check("R3 slot63", gotData, mkTte(1, 1, 16'd63));
    issue(OP_SRCH, 0, 64'h1011);
    check("R7 hit", gotData, 64'h1011);
    issue(OP_SRCH, 0, 64'h2222);
    check("R7 miss", gotData, 64'd0);
  endtask

  task automatic t_full();
    issue(OP_RW, 6, 64'hDEAD);
    issue(OP_AUTO, 0, mkTte(1, 0, 16'hEEEE));
    check("R5 drop flag", {63'd0, gotFull}, 64'd1);
    check("R5 done with drop", {63'd0, gotDone}, 64'd1);
    issue(OP_ERD, 0, '0);
    check("R5 slot0 intact", gotData, mkTte(1, 1, 16'd0));
    issue(OP_ERD, 63, '0);
    check("R5 slot63 intact", gotData, mkTte(1, 1, 16'd63));
    issue(OP_SRCH, 0, 64'hDEAD);
    check("R5 tag not installed", gotData, 64'd0);
  endtask

  task automatic t_unlocked();
    issue(OP_RW, 6, 64'h5555);
    issue(OP_DIR, 10, mkTte(1, 0, 16'h00AA));
    issue(OP_ERD, 10, '0);
    check("R6 direct entry", gotData, mkTte(1, 0, 16'h00AA));
    issue(OP_SRCH, 0, 64'h5555);
    check("R6 direct tag", gotData, 64'h5555);
    issue(OP_RW, 6, 64'h7777);
    issue(OP_AUTO, 0, mkTte(1, 1, 16'h00BB));
    check("R4 no drop", {63'd0, gotFull}, 64'd0);
    issue(OP_ERD, 10, '0);
    check("R4 unlocked slot replaced", gotData, mkTte(1, 1, 16'h00BB));
    issue(OP_ERD, 9, '0);
    check("R4 locked neighbour kept", gotData, mkTte(1, 1, 16'd9));
    issue(OP_SRCH, 0, 64'h5555);
    check("R4 old tag gone", gotData, 64'd0);
    issue(OP_SRCH, 0, 64'h7777);
    check("R4 new tag present", gotData, 64'h7777);
  endtask

  task automatic t_invalid_first();
    issue(OP_RW, 6, 64'h9999);
    issue(OP_DIR, 40, mkTte(0, 0, 16'h0040));
    issue(OP_SRCH, 0, 64'h9999);
    check("R7 invalid slot ignored", gotData, 64'd0);
    issue(OP_RW, 6, 64'h3333);
    issue(OP_DIR, 12, mkTte(1, 0, 16'h00CC));
    issue(OP_RW, 6, 64'h4444);
    issue(OP_AUTO, 0, mkTte(1, 1, 16'h00DD));
    issue(OP_ERD, 40, '0);
    check("R3 invalid slot chosen", gotData, mkTte(1, 1, 16'h00DD));
    issue(OP_ERD, 12, '0);
    check("R3 unlocked slot untouched", gotData, mkTte(1, 0, 16'h00CC));
    issue(OP_SRCH, 0, 64'h4444);
    check("R3 tag from reg6", gotData, 64'h4444);
  endtask

  task automatic t_badop();
    issue(3'd7, 12, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R12 done on unused code", {63'd0, gotDone}, 64'd1);
    check("R12 zero result", gotData, 64'd0);
    issue(3'd6, 12, 64'h0);
    issue(OP_ERD, 12, '0);
    check("R12 no state change", gotData, mkTte(1, 0, 16'h00CC));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_fault();
    t_fill();
    t_full();
    t_unlocked();
    t_invalid_first();
    t_badop();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule